// File: doc/BRIEF.md
# UART Interrupt Source Arbiter

This block gathers the event sources of a UART and turns them into one interrupt request and one readable identification byte. Five conditions can ask for service: receiver line errors, received data (reaching the FIFO trigger level, or a character timeout), the transmit holding register becoming empty, and a modem-status change. Each condition is gated by its own bit in an enable register. Only the most urgent enabled condition is reported at a time.

The FIFO storage, shift registers and baud logic sit outside the block. They supply the receive FIFO occupancy, push and pop strobes, a one-cycle pulse per character time, the line error flags, the holding-register-empty level and the modem-change flag. Register writes and the identification read arrive as single-cycle strobes. The identification byte, the enable readback and the interrupt line are registered. They follow their inputs one clock later.

Top module: `uart_irq_ident`

## Requirements
- R1: An enable write keeps write data bits 3:0 (bit 0 received data and timeout, bit 1 holding register empty, bit 2 line status, bit 3 modem status). The enable readback always returns 0 in bits 7:4.
- R2: The identification bits 2:1 report the highest-priority enabled pending source: 11 line status, then 10 received data, then 01 holding register empty, then 00 modem status.
- R3: Identification bit 0 is 0 while any enabled source is pending and 1 otherwise. With nothing pending, bits 3:0 read 0001.
- R4: A source whose enable bit is 0 is never reported and never raises the interrupt.
- R5: Identification bits 7:6 read 11 while the FIFO is enabled (FIFO control write data bit 0 = 1) and 00 while it is disabled. Bits 5:4 always read 0.
- R6: The received-data source is pending when the FIFO occupancy is at least the trigger level. FIFO control write bits 7:6 select the level: 00 = 1, 01 = 4, 10 = 8, 11 = 14. With the FIFO disabled the level is 1.
- R7: With the FIFO enabled and holding data, four character-time pulses with no push and no pop raise a timeout. The timeout is reported as code 10 with bit 3 set. Three pulses do not raise it.
- R8: Any push or pop restarts the timeout count. A pop clears a pending timeout.
- R9: The holding-register-empty source is set when the empty input rises. It is cleared by a holding register write, or by an identification read while bits 3:0 read 0010. A read while another code is shown leaves it set.
- R10: The line-status source is pending whenever any of the four line error inputs is 1.
- R11: The interrupt output is 1 only when identification bit 0 is 0 and the master enable input is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ier_wr | input | 1 | Enable register write strobe |
| ier_wdata | input | 8 | Enable register write data |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write data (bit 0 enable, bits 7:6 trigger) |
| rx_count | input | CNT_W | Receive FIFO occupancy |
| rx_push | input | 1 | A byte entered the receive FIFO |
| rx_pop | input | 1 | A byte was read from the receive FIFO |
| char_tick | input | 1 | One pulse per character time |
| lsr_err | input | 4 | Line error flags (overrun, parity, framing, break) |
| thr_empty | input | 1 | Transmit holding register empty level |
| thr_wr | input | 1 | Transmit holding register write strobe |
| msr_chg | input | 1 | Modem status change flag |
| iir_rd | input | 1 | Identification register read strobe |
| master_en | input | 1 | Master interrupt enable |
| ier_q | output | 8 | Enable register readback |
| iir_q | output | 8 | Identification byte |
| irq | output | 1 | Interrupt request |

## Verification
The bench builds the block with the default CNT_W of 5 and TO_CHARS of 4. A 5-bit occupancy lets it drive counts just below and at every trigger level, including 13 and 14 for the top level. The short timeout window lets it count character pulses one by one and show that the third pulse does not fire the timeout and the fourth does. It also shows that a push in mid-window restarts the count.

// File: rtl/uart_irq_pkg.sv
package uart_irq_pkg;

  typedef enum logic [1:0] {
    ID_MODEM  = 2'b00,
    ID_THRE   = 2'b01,
    ID_RXDATA = 2'b10,
    ID_LINE   = 2'b11
  } irq_id_e;

  // request index order: 0 = line, 1 = rx data, 2 = thre, 3 = modem
  localparam int NUM_SRC = 4;

  typedef struct packed {
    logic [1:0] trig;
    logic       fifo_on;
  } fifo_ctl_t;

  function automatic int unsigned trig_level(input logic [1:0] sel);
    case (sel)
      2'b00:   return 1;
      2'b01:   return 4;
      2'b10:   return 8;
      default: return 14;
    endcase
  endfunction

endpackage

// File: rtl/uart_irq_trig.sv
module uart_irq_trig #(
  parameter int CNT_W = 5
) (
  input  logic             fifo_on,
  input  logic [1:0]       trig,
  input  logic [CNT_W-1:0] rx_count,
  output logic             rda
);
  import uart_irq_pkg::*;

  logic [CNT_W-1:0] level;

  always_comb begin
    if (fifo_on) level = CNT_W'(trig_level(trig));
    else         level = CNT_W'(1);
    rda = (rx_count >= level);
  end
endmodule

// File: rtl/uart_irq_tmo.sv
module uart_irq_tmo #(
  parameter int TO_CHARS = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic armed,
  input  logic restart,
  input  logic clr,
  input  logic tick,
  output logic pend
);
  localparam int TO_W = $clog2(TO_CHARS + 1);
  localparam logic [TO_W-1:0] LAST = TO_W'(TO_CHARS - 1);

  logic [TO_W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      pend <= 1'b0;
    end else begin
      if (!armed || restart) begin
        cnt <= '0;
      end else if (tick && !pend) begin
        if (cnt == LAST) pend <= 1'b1;
        else             cnt  <= cnt + 1'b1;
      end
      if (!armed || clr) pend <= 1'b0;
    end
  end
endmodule

// File: rtl/uart_irq_prio.sv
module uart_irq_prio
  import uart_irq_pkg::*;
(
  input  logic [NUM_SRC-1:0] req,
  output logic               pend,
  output irq_id_e            id
);
  always_comb begin
    pend = 1'b0;
    id   = ID_MODEM;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req[i]) begin
        pend = 1'b1;
        id   = irq_id_e'(2'(NUM_SRC - 1 - i));
      end
    end
  end
endmodule

// File: rtl/uart_irq_ident.sv
module uart_irq_ident
  import uart_irq_pkg::*;
#(
  parameter int CNT_W    = 5,
  parameter int TO_CHARS = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ier_wr,
  input  logic [7:0]       ier_wdata,
  input  logic             fcr_wr,
  input  logic [7:0]       fcr_wdata,
  input  logic [CNT_W-1:0] rx_count,
  input  logic             rx_push,
  input  logic             rx_pop,
  input  logic             char_tick,
  input  logic [3:0]       lsr_err,
  input  logic             thr_empty,
  input  logic             thr_wr,
  input  logic             msr_chg,
  input  logic             iir_rd,
  input  logic             master_en,
  output logic [7:0]       ier_q,
  output logic [7:0]       iir_q,
  output logic             irq
);
  localparam logic [3:0] THRE_SHOWN = 4'b0010;

  logic [3:0]         ier_r;
  fifo_ctl_t          fctl;
  logic               thr_prev;
  logic               thre_pend;
  logic               rda;
  logic               tmo_pend;
  logic [NUM_SRC-1:0] req;
  logic               pend;
  irq_id_e            id;
  logic [7:0]         iir_d;

  assign ier_q = {4'b0000, ier_r};

  uart_irq_trig #(.CNT_W(CNT_W)) u_trig (
    .fifo_on  (fctl.fifo_on),
    .trig     (fctl.trig),
    .rx_count (rx_count),
    .rda      (rda)
  );

  uart_irq_tmo #(.TO_CHARS(TO_CHARS)) u_tmo (
    .clk     (clk),
    .rst     (rst),
    .armed   (fctl.fifo_on && (rx_count != '0)),
    .restart (rx_push || rx_pop),
    .clr     (rx_pop),
    .tick    (char_tick),
    .pend    (tmo_pend)
  );

  always_comb begin
    req[0] = ier_r[2] && (|lsr_err);
    req[1] = ier_r[0] && (rda || tmo_pend);
    req[2] = ier_r[1] && thre_pend;
    req[3] = ier_r[3] && msr_chg;
  end

  uart_irq_prio u_prio (
    .req  (req),
    .pend (pend),
    .id   (id)
  );

  always_comb begin
    iir_d      = 8'h00;
    iir_d[7:6] = {2{fctl.fifo_on}};
    iir_d[3]   = pend && (id == ID_RXDATA) && tmo_pend;
    iir_d[2:1] = pend ? id : ID_MODEM;
    iir_d[0]   = ~pend;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ier_r     <= '0;
      fctl      <= '0;
      thr_prev  <= 1'b0;
      thre_pend <= 1'b0;
      iir_q     <= 8'h01;
      irq       <= 1'b0;
    end else begin
      if (ier_wr) ier_r <= ier_wdata[3:0];
      if (fcr_wr) begin
        fctl.fifo_on <= fcr_wdata[0];
        fctl.trig    <= fcr_wdata[7:6];
      end
      thr_prev <= thr_empty;
      if (thr_empty && !thr_prev)
        thre_pend <= 1'b1;
      else if (thr_wr || (iir_rd && (iir_q[3:0] == THRE_SHOWN)))
        thre_pend <= 1'b0;
      iir_q <= iir_d;
      irq   <= pend && master_en;
    end
  end
endmodule

// File: rtl/uart_irq_ident_chk.sv
module uart_irq_ident_chk (
  input logic       clk,
  input logic       rst,
  input logic [3:0] lsr_err,
  input logic [7:0] ier_q,
  input logic [7:0] iir_q,
  input logic       irq
);
  AST_IER_UPPER_ZERO: assert property (@(posedge clk) disable iff (rst)
    ier_q[7:4] == 4'b0000); // R1
  AST_IDLE_CODE: assert property (@(posedge clk) disable iff (rst)
    iir_q[0] |-> (iir_q[3:1] == 3'b000)); // R3
  AST_FIFO_FIELD: assert property (@(posedge clk) disable iff (rst)
    (iir_q[7:6] == 2'b00 || iir_q[7:6] == 2'b11) && iir_q[5:4] == 2'b00); // R5
  AST_TMO_WITH_RX: assert property (@(posedge clk) disable iff (rst)
    iir_q[3] |-> (iir_q[2:1] == 2'b10)); // R7
  AST_LINE_WINS: assert property (@(posedge clk) disable iff (rst)
    (ier_q[2] && (|lsr_err)) |=> (iir_q[3:0] == 4'b0110)); // R10
  AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
    irq |-> !iir_q[0]); // R11
endmodule

bind uart_irq_ident uart_irq_ident_chk u_chk (
  .clk     (clk),
  .rst     (rst),
  .lsr_err (lsr_err),
  .ier_q   (ier_q),
  .iir_q   (iir_q),
  .irq     (irq)
);

// File: tb/uart_irq_ident_bench.sv
module uart_irq_ident_bench;
  localparam int CNT_W = 5;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             ier_wr = 0, fcr_wr = 0;
  logic [7:0]       ier_wdata = 0, fcr_wdata = 0;
  logic [CNT_W-1:0] rx_count = 0;
  logic             rx_push = 0, rx_pop = 0, char_tick = 0;
  logic [3:0]       lsr_err = 0;
  logic             thr_empty = 0, thr_wr = 0, msr_chg = 0, iir_rd = 0;
  logic             master_en = 0;
  logic [7:0]       ier_q, iir_q;
  logic             irq;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  uart_irq_ident #(.CNT_W(CNT_W), .TO_CHARS(4)) u_uart_irq_ident (.*);

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic wr_ier(input logic [7:0] d);
    ier_wdata = d; ier_wr = 1; step(1); ier_wr = 0;
  endtask

  task automatic wr_fcr(input logic [7:0] d);
    fcr_wdata = d; fcr_wr = 1; step(1); fcr_wr = 0;
  endtask

  task automatic pulse_tick(input int n);
    for (int i = 0; i < n; i++) begin
      char_tick = 1; step(1); char_tick = 0; step(1);
    end
  endtask

  task automatic t_reset();
    rst = 1; step(3); rst = 0; step(1);
    chk("R3 reset iir", iir_q, 8'h01);
    chk("R1 reset ier", ier_q, 8'h00);
    chk("R11 reset irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_ier();
    wr_ier(8'hFF); step(1);
    chk("R1 upper bits zero", ier_q, 8'h0F);
    wr_ier(8'h00); step(2);
  endtask

  task automatic t_disabled();
    lsr_err = 4'hF; msr_chg = 1; rx_count = 3; master_en = 1; step(3);
    chk("R4 disabled sources", iir_q, 8'h01);
    chk("R4 no irq", {7'd0, irq}, 8'h00);
    lsr_err = 0; msr_chg = 0; rx_count = 0; master_en = 0; step(2);
  endtask

  task automatic t_priority();
    wr_ier(8'h0F);
    lsr_err = 4'b0100; rx_count = 1; thr_empty = 1; msr_chg = 1; step(3);
    chk("R2 R10 line first", iir_q, 8'h06);
    lsr_err = 0; step(2);
    chk("R2 rx data second", iir_q, 8'h04);
    rx_count = 0; step(2);
    chk("R2 thre third", iir_q, 8'h02);
    thr_wr = 1; thr_empty = 0; step(1); thr_wr = 0; step(2);
    chk("R2 R9 modem after write", iir_q, 8'h00);
    msr_chg = 0; step(2);
    chk("R3 none pending", iir_q, 8'h01);
    wr_ier(8'h00); step(2);
  endtask

  task automatic t_thre();
    wr_ier(8'h06);
    thr_empty = 1; lsr_err = 4'b0001; step(3);
    chk("R10 line hides thre", iir_q, 8'h06);
    iir_rd = 1; step(1); iir_rd = 0;
    lsr_err = 0; step(2);
    chk("R9 read of other code keeps thre", iir_q, 8'h02);
    iir_rd = 1; step(1); iir_rd = 0; step(2);
    chk("R9 read clears thre", iir_q, 8'h01);
    thr_empty = 0; step(1); thr_empty = 1; step(3);
    chk("R9 new empty edge", iir_q, 8'h02);
    thr_empty = 0; thr_wr = 1; step(1); thr_wr = 0;
    wr_ier(8'h00); step(2);
  endtask

  task automatic t_trigger();
    wr_ier(8'h01);
    rx_count = 1; step(3);
    chk("R6 R5 no fifo level 1", iir_q, 8'h04);
    wr_fcr(8'h41); rx_count = 3; step(2);
    chk("R6 R5 level4 below", iir_q, 8'hC1);
    rx_count = 4; step(2);
    chk("R6 level4 at", iir_q, 8'hC4);
    wr_fcr(8'h81); rx_count = 7; step(2);
    chk("R6 level8 below", iir_q, 8'hC1);
    rx_count = 8; step(2);
    chk("R6 level8 at", iir_q, 8'hC4);
    wr_fcr(8'hC1); rx_count = 13; step(2);
    chk("R6 level14 below", iir_q, 8'hC1);
    rx_count = 14; step(2);
    chk("R6 level14 at", iir_q, 8'hC4);
    wr_fcr(8'h01); rx_count = 1; step(2);
    chk("R6 level1 at", iir_q, 8'hC4);
    wr_fcr(8'h00); rx_count = 0; step(2);
    chk("R5 fifo off", iir_q, 8'h01);
    wr_ier(8'h00); step(1);
  endtask

  task automatic t_timeout();
    wr_ier(8'h01); wr_fcr(8'hC1);
    rx_count = 3; rx_push = 1; step(1); rx_push = 0; step(1);
    pulse_tick(3); step(1);
    chk("R7 three ticks quiet", iir_q, 8'hC1);
    pulse_tick(1); step(1);
    chk("R7 fourth tick timeout", iir_q, 8'hCC);
    rx_pop = 1; rx_count = 2; step(1); rx_pop = 0; step(2);
    chk("R8 pop clears timeout", iir_q, 8'hC1);
    pulse_tick(2);
    rx_push = 1; rx_count = 3; step(1); rx_push = 0; step(1);
    pulse_tick(2); step(1);
    chk("R8 push restarts count", iir_q, 8'hC1);
    pulse_tick(2); step(1);
    chk("R8 R7 timeout after restart", iir_q, 8'hCC);
    rx_pop = 1; rx_count = 0; step(1); rx_pop = 0;
    wr_fcr(8'h00); wr_ier(8'h00); step(2);
  endtask

  task automatic t_irq();
    wr_ier(8'h08); msr_chg = 1; master_en = 0; step(3);
    chk("R11 masked code", iir_q, 8'h00);
    chk("R11 masked irq", {7'd0, irq}, 8'h00);
    master_en = 1; step(2);
    chk("R11 irq on", {7'd0, irq}, 8'h01);
    msr_chg = 0; step(2);
    chk("R11 irq off when idle", {7'd0, irq}, 8'h00);
    master_en = 0; wr_ier(8'h00); step(1);
  endtask

  initial begin
    t_reset();
    t_ier();
    t_disabled();
    t_priority();
    t_thre();
    t_trigger();
    t_timeout();
    t_irq();
    if (!done) begin
      done = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      done = 1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule